// File: doc/BRIEF.md
# ADC serial readout controller

This block is the host side of a three-wire link to a 12-bit serial sampling converter. It drives an active-low strobe that doubles as convert start and chip select, drives the serial clock, and takes in the converter's serial data line. A single-cycle `start` request begins one transaction. The `mode` input, sampled at that request, picks how the transaction runs. In conversion mode (0), the falling strobe starts a conversion, and the controller holds off the clock for a fixed conversion wait before it reads. In sample mode (1), the falling strobe puts the converter into hold, and the read follows at once.

Each read is a 16-clock frame. The first four bits are a zero header, followed by the 12-bit result, most significant bit first. The clock idles high. Its low and high phases each last `sclk_half` system clocks. The converter changes data on the falling clock edge, and the controller samples it on the rising edge. After the 16th rising edge the strobe returns high. A quiet interval then runs before another strobe fall is allowed, so no read can span a strobe falling edge. A good header gives a one-cycle `result_valid` pulse with the data. A non-zero header gives a one-cycle `proto_err` pulse instead.

Top module: `adc_readout_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycles after release, `adc_cs_n` and `adc_sclk` are high and `busy`, `result_valid` and `proto_err` are low.
- R2: Every transaction holds `adc_cs_n` low for exactly 16 falling and 16 rising edges of `adc_sclk`. `adc_sclk` is high whenever `adc_cs_n` is high.
- R3: Inside a frame, each low phase and each high phase of `adc_sclk` lasts `sclk_half` system clocks. A value of 0 acts as 1.
- R4: In mode 0, at least `CONV_CYCLES` system clocks pass between the fall of `adc_cs_n` and the first fall of `adc_sclk`.
- R5: In mode 1, the first fall of `adc_sclk` comes no more than `sclk_half`+2 system clocks after `adc_cs_n` falls.
- R6: The bit sampled on the k-th rising edge is bit 16-k of the frame word. When bits 15..12 are all zero, `result` takes bits 11..0 and `result_valid` pulses for exactly one cycle.
- R7: When any of bits 15..12 is one, `proto_err` pulses for one cycle, `result_valid` stays low, and `result` keeps its previous value.
- R8: `adc_cs_n` rises only after the 16th rising edge of the frame. It then stays high for at least `QUIET_CYCLES` system clocks before it can fall again.
- R9: A `start` or a `mode` change while `busy` is high has no effect: no extra frame, and no change to the timing of the running transaction.
- R10: `busy` is high from the cycle after an accepted `start` until the quiet interval ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Single-cycle transaction request, accepted when idle |
| mode | input | 1 | 0 = conversion wait before read, 1 = read at once |
| sclk_half | input | DIV_W | Serial clock half-period in system clocks |
| adc_cs_n | output | 1 | Active-low convert/chip-select strobe |
| adc_sclk | output | 1 | Serial clock to the converter, idles high |
| adc_sdata | input | 1 | Serial data from the converter |
| busy | output | 1 | Transaction or quiet interval in progress |
| result | output | DATA_BITS | Last good 12-bit conversion result |
| result_valid | output | 1 | One-cycle pulse when `result` is updated |
| proto_err | output | 1 | One-cycle pulse when the header bits are non-zero |

## Verification
The bench targets the shortest clock setting, where `sclk_half` is 0 or 1. Here a controller that keeps the clock running for one cycle after the last sample would add a 17th falling edge and corrupt the frame count. It drives headers with a single one bit and with all bits set. A design that trusted the header, or that took the wrong 12 bits, would then pulse `result_valid` or overwrite the held result. It raises `start` and flips `mode` in the middle of a transaction, where a controller that re-sampled them would add a frame or skip the conversion wait. It also measures the gap between one strobe rise and the next strobe fall, so a shortened quiet interval shows up as a read that comes too close to the next conversion edge.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_READ  = 2'd2,
    ST_QUIET = 2'd3
  } rd_state_t;

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             sclk,
  output logic             rise_evt
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] half_m1;
  logic             sclk_q, sclk_d;
  logic             wrap;

  always_comb begin
    half_m1 = (half == '0) ? '0 : half - 1'b1;
    wrap    = run && (cnt_q >= half_m1);
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b1;
    end else if (wrap) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      sclk_d = sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk     = sclk_q;
  assign rise_evt = wrap && !sclk_q;

  // The clock must rest high whenever the frame is not running
  assert_sclk_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> sclk_q);

endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  sample_en,
  input  logic                  sdata,
  output logic [FRAME_BITS-1:0] word,
  output logic                  done
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  done_q, done_d;

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (clear) begin
      cnt_d = '0;
    end else if (sample_en) begin
      shift_d = {shift_q[FRAME_BITS-2:0], sdata};
      cnt_d   = cnt_q + 1'b1;
      done_d  = (cnt_q == CNT_W'(FRAME_BITS - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign word = shift_q;
  assign done = done_q;

  // Rising edges are at least two cycles apart, so completion is a lone pulse
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // The wait counter must never wrap below zero
  assert_timer_holds_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));

endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int FRAME_BITS   = 16,
  parameter int DATA_BITS    = 12,
  parameter int CONV_CYCLES  = 330,
  parameter int QUIET_CYCLES = 50
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 mode,
  input  logic [DIV_W-1:0]     sclk_half,
  output logic                 adc_cs_n,
  output logic                 adc_sclk,
  input  logic                 adc_sdata,
  output logic                 busy,
  output logic [DATA_BITS-1:0] result,
  output logic                 result_valid,
  output logic                 proto_err
);

  localparam int HDR_BITS = FRAME_BITS - DATA_BITS;
  localparam int TMR_MAX  = (CONV_CYCLES > QUIET_CYCLES) ? CONV_CYCLES : QUIET_CYCLES;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  rd_state_t             state_q, state_d;
  logic                  cs_q, cs_d;
  logic [DATA_BITS-1:0]  res_q, res_d;
  logic                  vld_q, vld_d;
  logic                  err_q, err_d;
  logic                  tmr_load;
  logic [TMR_W-1:0]      tmr_val;
  logic                  tmr_zero;
  logic                  sclk_run;
  logic                  rise_evt;
  logic                  frame_done;
  logic [FRAME_BITS-1:0] frame_word;

  assign sclk_run = (state_q == ST_READ) && !frame_done;

  adc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .run      (sclk_run),
    .half     (sclk_half),
    .sclk     (adc_sclk),
    .rise_evt (rise_evt)
  );

  adc_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clear     (state_q == ST_IDLE),
    .sample_en (rise_evt),
    .sdata     (adc_sdata),
    .word      (frame_word),
    .done      (frame_done)
  );

  adc_wait_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    cs_d     = cs_q;
    res_d    = res_q;
    vld_d    = 1'b0;
    err_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cs_d = 1'b0;
          if (mode) begin
            state_d = ST_READ;
          end else begin
            state_d  = ST_CONV;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(CONV_CYCLES);
          end
        end
      end
      ST_CONV: begin
        if (tmr_zero) state_d = ST_READ;
      end
      ST_READ: begin
        if (frame_done) begin
          state_d  = ST_QUIET;
          cs_d     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(QUIET_CYCLES);
          if (frame_word[FRAME_BITS-1 -: HDR_BITS] == '0) begin
            res_d = frame_word[DATA_BITS-1:0];
            vld_d = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_QUIET: begin
        if (tmr_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      res_q   <= '0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_d;
      res_q   <= res_d;
      vld_q   <= vld_d;
      err_q   <= err_d;
    end
  end

  assign adc_cs_n     = cs_q;
  assign busy         = (state_q != ST_IDLE);
  assign result       = res_q;
  assign result_valid = vld_q;
  assign proto_err    = err_q;

  assert_sclk_high_when_deselected_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    adc_cs_n |-> adc_sclk);

  assert_valid_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    result_valid |=> !result_valid);

  assert_err_excludes_valid_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(result_valid && proto_err));

  assert_strobe_falls_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(adc_cs_n) |-> ($past(state_q) == ST_IDLE));

  assert_quiet_keeps_strobe_high_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_QUIET) |-> adc_cs_n);

  assert_start_ignored_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && start) |=> !$fell(adc_cs_n));

endmodule

// File: tb/adc_readout_ctrl_test.sv
module adc_readout_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int CONV       = 330;
  localparam int QUIET      = 50;
  localparam int WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        mode;
  logic [7:0]  sclk_half;
  logic        adc_cs_n;
  logic        adc_sclk;
  logic        adc_sdata;
  logic        busy;
  logic [11:0] result;
  logic        result_valid;
  logic        proto_err;

  adc_readout_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .sclk_half(sclk_half),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdata(adc_sdata), .busy(busy),
    .result(result), .result_valid(result_valid), .proto_err(proto_err)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_good(input logic [15:0] w);
    return (w[15:12] == 4'h0);
  endfunction

  function automatic int exp_data(input logic [15:0] w);
    return int'(w[11:0]);
  endfunction

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // Converter model: new bit after each falling clock edge while selected
  logic [15:0] dev_word;
  int          dev_idx;
  initial begin
    adc_sdata = 1'b0;
    dev_idx   = 0;
    forever begin
      @(negedge adc_sclk or negedge adc_cs_n);
      if (!adc_cs_n && !adc_sclk) begin
        if (dev_idx < 16) adc_sdata = dev_word[15 - dev_idx];
        dev_idx++;
      end else if (!adc_cs_n) begin
        dev_idx   = 0;
        adc_sdata = 1'b0;
      end
    end
  end

  // Monitor, sampling midway between rising clock edges
  bit prev_cs = 1'b1, prev_sclk = 1'b1, prev_vld = 1'b0;
  int cur_mode = 0;
  int falls = 0, rises = 0, run_len = 0, pre = 0, hi_quiet = 0;
  bit had_frame = 1'b0, idle_bad = 1'b0, half_bad = 1'b0, pulse_bad = 1'b0;
  int valid_cnt = 0, err_cnt = 0, frames = 0;
  int cycles = 0;
  bit timed_out = 1'b0;

  always @(negedge clk) begin
    int h;
    h = (sclk_half == 0) ? 1 : int'(sclk_half);
    cycles++;
    if (rst_n) begin
      if (!adc_cs_n && prev_cs) begin
        if (had_frame)
          check(hi_quiet >= QUIET, "R8", "quiet cycles before strobe fall", hi_quiet, QUIET);
        check(!idle_bad, "R2", "sclk high while deselected", idle_bad, 0);
        idle_bad = 0; half_bad = 0;
        falls = 0; rises = 0; pre = 0; run_len = 0;
      end
      if (!adc_cs_n) begin
        if (adc_sclk != prev_sclk) begin
          if (!adc_sclk) begin
            if (falls == 0) begin
              if (cur_mode == 0)
                check(pre >= CONV, "R4", "cycles before first sclk fall", pre, CONV);
              else
                check(pre <= h + 2, "R5", "cycles before first sclk fall", pre, h + 2);
            end else if (run_len != h) half_bad = 1;
            falls++;
          end else begin
            if (run_len != h) half_bad = 1;
            rises++;
          end
          run_len = 1;
        end else begin
          run_len++;
          if (falls == 0) pre++;
        end
      end else begin
        if (!prev_cs) begin
          check(falls == 16 && rises == 16, "R2", "sclk falls+rises per frame",
                falls + rises, 32);
          check(!half_bad, "R3", "half-period mismatch flag", half_bad, 0);
          had_frame = 1; hi_quiet = 0; frames++;
        end
        hi_quiet++;
        if (!adc_sclk) idle_bad = 1;
      end
      if (result_valid) valid_cnt++;
      if (proto_err) err_cnt++;
      if (result_valid && prev_vld) pulse_bad = 1;
    end
    prev_cs   = adc_cs_n;
    prev_sclk = adc_sclk;
    prev_vld  = result_valid;
    if (cycles > WATCHDOG && !timed_out) begin
      timed_out = 1;
      check(0, "WDOG", "watchdog expired at cycle", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  int exp_res = 0;

  task automatic run_txn(input bit m, input logic [15:0] w, input int h, input bit poke);
    int v0, e0, f0, wait_n;
    dev_word  = w;
    sclk_half = 8'(h);
    cur_mode  = m;
    v0 = valid_cnt; e0 = err_cnt; f0 = frames;
    @(negedge clk);
    mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", "busy after accepted start", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; mode = ~m;
      @(negedge clk);
      start = 1'b0; mode = m;
    end
    wait_n = 0;
    while (busy && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    check(!busy, "R10", "busy drops after quiet", busy, 0);
    check(frames == f0 + 1, "R9", "frames per accepted start", frames - f0, 1);
    if (exp_good(w)) begin
      check(valid_cnt == v0 + 1 && err_cnt == e0, "R6", "valid pulses", valid_cnt - v0, 1);
      check(int'(result) == exp_data(w), "R6", "result data", int'(result), exp_data(w));
      exp_res = exp_data(w);
    end else begin
      check(err_cnt == e0 + 1 && valid_cnt == v0, "R7", "error pulses", err_cnt - e0, 1);
      check(int'(result) == exp_res, "R7", "result held", int'(result), exp_res);
    end
    check(!pulse_bad, "R6", "valid pulse width over one", pulse_bad, 0);
  endtask

  initial begin
    logic [15:0] w;
    start = 1'b0; mode = 1'b0; sclk_half = 8'd2; dev_word = 16'h0;
    rst_n = 1'b0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check(adc_cs_n && adc_sclk && !busy && !result_valid && !proto_err,
          "R1", "idle outputs in reset", {adc_cs_n, adc_sclk, busy, result_valid, proto_err}, 24);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(adc_cs_n && adc_sclk && !busy && !result_valid && !proto_err,
          "R1", "idle outputs after release", {adc_cs_n, adc_sclk, busy, result_valid, proto_err}, 24);

    // Directed corners
    run_txn(1'b0, 16'h0FFF, 1, 1'b0);
    run_txn(1'b1, 16'h0A5A, 0, 1'b0);
    run_txn(1'b0, 16'h8001, 2, 1'b0);
    run_txn(1'b1, 16'hF000, 1, 1'b0);
    run_txn(1'b1, 16'h1FFF, 3, 1'b0);
    run_txn(1'b1, 16'h0123, 5, 1'b1);
    run_txn(1'b0, 16'h0800, 4, 1'b1);
    run_txn(1'b1, 16'h0001, 1, 1'b0);

    // Random traffic
    for (int i = 0; i < 30; i++) begin
      w = 16'($urandom);
      if (($urandom % 5) != 0) w[15:12] = 4'h0;
      run_txn(1'($urandom), w, int'($urandom % 5), 1'($urandom % 4 == 0));
      repeat ($urandom % 6) @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule